// File: doc/BRIEF.md
# Programmable Interval Alarm Timer

The block counts pulses from one of four tick sources and raises an alarm when the count reaches a programmed interval. A 2-bit select chooses the tick source. Each selected tick advances an 8-bit counter. A tick that arrives while the counter already equals the interval value is the matching tick: it produces the alarm instead of advancing the counter. A programmed interval of N therefore produces an alarm every N+1 selected ticks.

Control inputs enable the timer and choose what happens after a match:
- **Restart:** the counter returns to zero and keeps counting.
- **Single-shot:** the counter is held at zero until the enable is cycled.

The alarm appears in two forms. One is a one-cycle event pulse for an interrupt controller. The other is a sticky flag that software clears. The tick sources are produced outside the block. They are single-cycle enable pulses in the system clock domain.

Top module: `interval_alarm_timer`

## Requirements
- R1: While `en_i` is low, `count_o` is 0 one cycle later, ticks are ignored and no alarm is produced.
- R2: Only `tick_i[src_sel_i]` advances the counter. The select value k picks bit k. Pulses on the other three tick bits leave `count_o` unchanged.
- R3: While enabled and not held, a selected tick with `count_o` not equal to `interval_i` raises `count_o` by one after that clock edge.
- R4: A selected tick with `count_o` equal to `interval_i` drives `alarm_evt_o` high for exactly the next cycle and sets `alarm_flag_o` in that same cycle. The alarm follows `interval_i`+1 selected ticks, so an interval of 0 alarms on the first tick after enabling.
- R5: With `single_shot_i` low, `count_o` is 0 after the matching tick, and the next selected tick makes it 1.
- R6: With `single_shot_i` high, `count_o` stays 0 after the matching tick. Further ticks are ignored and no further alarm occurs.
- R7: Driving `en_i` low and then high again releases a held counter, so the next selected tick counts.
- R8: `alarm_flag_o` stays set until `alarm_clr_i` is high at a clock edge. If a match occurs in that same cycle, the set wins and the flag stays 1.
- R9: After reset `count_o` is 0 and both `alarm_evt_o` and `alarm_flag_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Timer enable |
| src_sel_i | input | 2 | Tick source select |
| single_shot_i | input | 1 | 1: hold at zero after an alarm; 0: restart |
| interval_i | input | 8 | Programmed interval value |
| tick_i | input | 4 | Single-cycle tick pulses, one bit per source |
| alarm_clr_i | input | 1 | Clears the sticky alarm flag |
| count_o | output | 8 | Current counter value |
| alarm_evt_o | output | 1 | One-cycle alarm event pulse |
| alarm_flag_o | output | 1 | Sticky alarm flag |

## Verification
The bench probes several corner cases and the faults each one would expose:
- **Off-by-one compare.** The bench counts the exact number of ticks to each alarm. A design that compares after incrementing would be one tick early. The same design would never alarm on an interval of 0.
- **Source decode.** The bench pulses the unselected sources between real ticks. A swapped or wrongly decoded source select would advance the count on those pulses.
- **Restart and hold.** The bench sends one tick after each alarm. A restart/hold mix-up would show up as 1 where 0 is expected, or the reverse. A hold that survives an enable cycle would leave the count stuck at zero.
- **Clear against set.** The bench raises a flag clear in the same cycle as a match. A design that lets the clear win would lose that alarm.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int unsigned CNT_W_DEF = 8;
  localparam int unsigned N_SRC_DEF = 4;

  typedef enum logic {
    MODE_RESTART = 1'b0,
    MODE_HOLD    = 1'b1
  } after_match_e;
endpackage

// File: rtl/tick_select.sv
module tick_select #(
  parameter int unsigned N_SRC = 4,
  localparam int unsigned SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [N_SRC-1:0] hit;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign hit[g] = tick_i[g] && (sel_i == SEL_W'(g));
  end

  assign tick_o = |hit;

  always_comb begin
    assert ($onehot0(hit)); // R2: at most one source contributes
  end
endmodule

// File: rtl/interval_counter.sv
module interval_counter
  import timer_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] interval_i,
  input  after_match_e     mode_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             match_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             held_q;

  assign match_o = en_i && !held_q && tick_i && (cnt_q == interval_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      held_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      held_q <= 1'b0;
    end else if (held_q) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_q == interval_i) begin
        cnt_q  <= '0;
        held_q <= (mode_i == MODE_HOLD);
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign cnt_o = cnt_q;

  assert_disabled_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));

  assert_count_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !held_q && tick_i && (cnt_q != interval_i)) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  assert_match_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> (cnt_q == '0));

  assert_hold_sticks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && held_q) |=> (held_q && cnt_q == '0 && !match_o));

  assert_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !held_q);
endmodule

// File: rtl/alarm_latch.sv
module alarm_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic match_i,
  input  logic clr_i,
  output logic evt_o,
  output logic flag_o
);
  logic evt_q, flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      evt_q  <= match_i;
      flag_q <= match_i || (flag_q && !clr_i); // set wins over clear
    end
  end

  assign evt_o  = evt_q;
  assign flag_o = flag_q;

  assert_alarm_out_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_i |=> (evt_q && flag_q));

  assert_evt_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !match_i |=> !evt_q);

  assert_flag_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);

  assert_flag_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !match_i) |=> !flag_q);
endmodule

// File: rtl/interval_alarm_timer.sv
module interval_alarm_timer
  import timer_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF,
  parameter int unsigned N_SRC = N_SRC_DEF,
  localparam int unsigned SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] src_sel_i,
  input  logic             single_shot_i,
  input  logic [CNT_W-1:0] interval_i,
  input  logic [N_SRC-1:0] tick_i,
  input  logic             alarm_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             alarm_evt_o,
  output logic             alarm_flag_o
);
  logic         sel_tick;
  logic         match;
  after_match_e mode;

  assign mode = single_shot_i ? MODE_HOLD : MODE_RESTART;

  tick_select #(.N_SRC(N_SRC)) u_sel (
    .tick_i (tick_i),
    .sel_i  (src_sel_i),
    .tick_o (sel_tick)
  );

  interval_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .tick_i     (sel_tick),
    .interval_i (interval_i),
    .mode_i     (mode),
    .cnt_o      (count_o),
    .match_o    (match)
  );

  alarm_latch u_alarm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .match_i (match),
    .clr_i   (alarm_clr_i),
    .evt_o   (alarm_evt_o),
    .flag_o  (alarm_flag_o)
  );

  assert_no_alarm_disabled_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !alarm_evt_o);
endmodule

// File: tb/interval_alarm_timer_test.sv
module interval_alarm_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [1:0] sel = '0;
  logic       ss = 1'b0;
  logic [7:0] iv = '0;
  logic [3:0] tick = '0;
  logic       clr = 1'b0;
  logic [7:0] count;
  logic       evt, flag;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  interval_alarm_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .src_sel_i(sel),
    .single_shot_i(ss), .interval_i(iv), .tick_i(tick),
    .alarm_clr_i(clr), .count_o(count), .alarm_evt_o(evt), .alarm_flag_o(flag)
  );

  // {sel[1:0], single_shot, interval[7:0]}
  localparam logic [10:0] VEC [6] = '{
    {2'd0, 1'b0, 8'd3},
    {2'd1, 1'b0, 8'd0},
    {2'd2, 1'b1, 8'd5},
    {2'd3, 1'b1, 8'd1},
    {2'd0, 1'b1, 8'd0},
    {2'd2, 1'b0, 8'd7}
  };

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(logic [3:0] t, logic c);
    @(negedge clk);
    tick = t;
    clr  = c;
    @(posedge clk);
    #1;
    tick = '0;
    clr  = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    #9;
    chk("R9 count", count, 8'd0);
    chk("R9 evt", {7'd0, evt}, 8'd0);
    chk("R9 flag", {7'd0, flag}, 8'd0);
    @(negedge clk);
    rst_n = 1'b1;

    foreach (VEC[v]) begin
      logic [1:0] vs  = VEC[v][10:9];
      logic       vss = VEC[v][8];
      logic [7:0] viv = VEC[v][7:0];
      logic [3:0] sel_mask = 4'b1 << vs;
      @(negedge clk);
      en = 1'b0; sel = vs; ss = vss; iv = viv; clr = 1'b1;
      @(negedge clk);
      clr = 1'b0; en = 1'b1;
      for (int i = 0; i <= int'(viv); i++) begin
        step(~sel_mask, 1'b0);
        chk("R2 other sources ignored", count, 8'(i));
        step(sel_mask, 1'b0);
        if (i < int'(viv)) begin
          chk("R3 increment", count, 8'(i + 1));
          chk("R4 no early alarm", {7'd0, evt}, 8'd0);
        end else begin
          chk("R4 alarm event", {7'd0, evt}, 8'd1);
          chk("R4 alarm flag", {7'd0, flag}, 8'd1);
          chk("R5 count zero after match", count, 8'd0);
        end
      end
      step('0, 1'b0);
      chk("R4 event one cycle", {7'd0, evt}, 8'd0);
      step(sel_mask, 1'b0);
      if (vss) begin
        chk("R6 held", count, 8'd0);
        chk("R6 no second alarm", {7'd0, evt}, 8'd0);
      end else if (viv == 8'd0) begin
        chk("R5 restart alarm", {7'd0, evt}, 8'd1);
      end else begin
        chk("R5 restart count", count, 8'd1);
      end
    end

    // R1: disable clears the count, ticks ignored
    @(negedge clk);
    en = 1'b0; sel = 2'd1; ss = 1'b0; iv = 8'd10;
    @(negedge clk);
    en = 1'b1;
    step(4'b0010, 1'b0);
    step(4'b0010, 1'b0);
    chk("R3 count before disable", count, 8'd2);
    @(negedge clk);
    en = 1'b0;
    @(posedge clk); #1;
    chk("R1 disable clears", count, 8'd0);
    step(4'b1111, 1'b0);
    chk("R1 ticks ignored", count, 8'd0);
    chk("R1 no alarm", {7'd0, evt}, 8'd0);

    // R7: re-enable releases hold
    @(negedge clk);
    sel = 2'd3; ss = 1'b1; iv = 8'd0; en = 1'b1;
    step(4'b1000, 1'b0);
    chk("R6 alarm then hold", {7'd0, evt}, 8'd1);
    step(4'b1000, 1'b0);
    chk("R6 still held", count, 8'd0);
    @(negedge clk);
    en = 1'b0; iv = 8'd4;
    @(negedge clk);
    en = 1'b1;
    step(4'b1000, 1'b0);
    chk("R7 released", count, 8'd1);

    // R8: sticky flag, clear, set wins
    step('0, 1'b0);
    step('0, 1'b0);
    chk("R8 flag sticky", {7'd0, flag}, 8'd1);
    step('0, 1'b1);
    chk("R8 flag cleared", {7'd0, flag}, 8'd0);
    step(4'b1000, 1'b0);
    step(4'b1000, 1'b0);
    step(4'b1000, 1'b0);
    chk("R3 at interval", count, 8'd4);
    step(4'b1000, 1'b1);
    chk("R8 set wins over clear", {7'd0, flag}, 8'd1);
    chk("R4 event with clear", {7'd0, evt}, 8'd1);

    finish_run();
  end
endmodule